// File: doc/BRIEF.md
# Flag-Setting Integer ALU with Carry Chaining

This block is a 32-bit integer arithmetic and logic unit that keeps a small architectural condition register. It computes add, add with stored carry, subtract, subtract with stored borrow, AND, OR and XOR. The result is produced combinationally from the operands, the opcode and the stored carry. The condition register holds carry, zero, negative, overflow and parity. It is updated on a clock edge only when the caller asks for it.

Every operation has two forms, selected by a set-flags input. One form writes the condition register. The other leaves it as it was, so that a flag needed by a later branch can survive unrelated arithmetic. The two carry-consuming operations take their carry-in from the stored carry flag. Software can therefore chain word-wide operations into multi-word additions and subtractions. The zero flag comes from an OR-reduction tree of logarithmic depth over the result.

Top module: `flag_alu`

## Requirements
- R1: While reset is low, flags_o reads 0. Flag bit positions are: [0] carry, [1] zero, [2] negative, [3] overflow, [4] parity.
- R2: result_o is produced combinationally from the operands and the opcode. op_i 0 gives a+b, 2 gives a-b, 4 gives a AND b, 5 gives a OR b and 6 gives a XOR b.
- R3: op_i 1 gives a+b+C and op_i 3 gives a+NOT(b)+C, where C is the stored carry flag. A 64-bit sum therefore chains as op 0 on the low words followed by op 1 on the high words.
- R4: A flag-setting arithmetic operation stores the carry out of bit 31 in the carry flag. For subtraction this is NOT borrow, so 1 means no borrow.
- R5: A flag-setting arithmetic operation sets overflow when a and the effective second operand (b, or NOT b for ops 2 and 3) have the same sign and the result's sign differs from it.
- R6: A flag-setting operation sets the zero flag exactly when all 32 result bits are 0.
- R7: A flag-setting operation copies result bit 31 into the negative flag.
- R8: A flag-setting operation sets the parity flag when the result holds an even number of ones.
- R9: A flag-setting logic operation (op_i 4, 5 or 6) clears carry and overflow.
- R10: The flags change only on a rising clock edge where valid_i and setf_i are both 1. Otherwise they hold, while result_o is still produced.
- R11: op_i 7 is reserved. It gives result_o 0 and never changes the flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operation strobe |
| setf_i | input | 1 | 1 selects the flag-writing form of the operation |
| op_i | input | 3 | Operation code |
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand |
| result_o | output | 32 | Combinational result |
| flags_o | output | 5 | Stored flags: parity, overflow, negative, zero, carry (bit 4 down to bit 0) |

## Verification
Only the flags are stored state. A wrong flag therefore shows at flags_o one cycle after the flag-setting operation. A wrong stored carry also shows directly in the result_o of the very next carry-consuming operation, in the same cycle it is issued. Flags that should have held are compared against the bench's model after every operation, so a spurious write is visible one edge after it happens. Chained 64-bit additions and subtractions tie both paths together.

// File: rtl/flag_alu_pkg.sv
package flag_alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_ADC = 3'd1,
        OP_SUB = 3'd2,
        OP_SBB = 3'd3,
        OP_AND = 3'd4,
        OP_OR  = 3'd5,
        OP_XOR = 3'd6,
        OP_RSV = 3'd7
    } alu_op_e;

    typedef struct packed {
        logic parity;
        logic overflow;
        logic negative;
        logic zero;
        logic carry;
    } cond_t;

    typedef struct packed {
        cond_t cond;
    } alu_state_t;

endpackage

// File: rtl/flag_alu_adder.sv
module flag_alu_adder #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         inv_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o,
    output logic         ovf_o
);
    logic [W-1:0] eff_b;
    logic [W:0]   wide;

    always_comb begin
        eff_b  = inv_i ? ~b_i : b_i;
        wide   = {1'b0, a_i} + {1'b0, eff_b} + {{W{1'b0}}, cin_i};
        sum_o  = wide[W-1:0];
        cout_o = wide[W];
        ovf_o  = (a_i[W-1] == eff_b[W-1]) && (wide[W-1] != a_i[W-1]);
    end
endmodule

// File: rtl/flag_alu_logic.sv
module flag_alu_logic
    import flag_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  alu_op_e      op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] res_o
);
    always_comb begin
        unique case (op_i)
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            default: res_o = '0;
        endcase
    end
endmodule

// File: rtl/flag_alu_zdet.sv
module flag_alu_zdet #(
    parameter int W = 32
) (
    input  logic [W-1:0] val_i,
    output logic         zero_o
);
    localparam int LEVELS = (W > 1) ? $clog2(W) : 0;
    localparam int LEAVES = 1 << LEVELS;
    localparam int NODES  = 2 * LEAVES - 1;

    // node 0 is the root; children of node k are 2k+1 and 2k+2
    logic [NODES-1:0] node;

    genvar gi;
    generate
        for (gi = 0; gi < LEAVES; gi++) begin : g_leaf
            if (gi < W) begin : g_used
                assign node[LEAVES - 1 + gi] = val_i[gi];
            end else begin : g_pad
                assign node[LEAVES - 1 + gi] = 1'b0;
            end
        end
        for (gi = 0; gi < LEAVES - 1; gi++) begin : g_inner
            assign node[gi] = node[2*gi + 1] | node[2*gi + 2];
        end
    endgenerate

    assign zero_o = ~node[0];
endmodule

// File: rtl/flag_alu.sv
module flag_alu
    import flag_alu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         valid_i,
    input  logic         setf_i,
    input  logic [2:0]   op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] result_o,
    output logic [4:0]   flags_o
);
    alu_state_t   st_d, st_q;
    alu_op_e      op;
    logic         is_sub, is_arith, cin;
    logic [W-1:0] sum, lres;
    logic         cout, ovf, zero;

    assign op = alu_op_e'(op_i);

    always_comb begin
        is_sub   = (op == OP_SUB) || (op == OP_SBB);
        is_arith = (op_i[2] == 1'b0);
        unique case (op)
            OP_ADD:  cin = 1'b0;
            OP_SUB:  cin = 1'b1;
            OP_ADC,
            OP_SBB:  cin = st_q.cond.carry;
            default: cin = 1'b0;
        endcase
    end

    flag_alu_adder #(.W(W)) adder_i (
        .a_i    (a_i),
        .b_i    (b_i),
        .inv_i  (is_sub),
        .cin_i  (cin),
        .sum_o  (sum),
        .cout_o (cout),
        .ovf_o  (ovf)
    );

    flag_alu_logic #(.W(W)) logic_i (
        .op_i  (op),
        .a_i   (a_i),
        .b_i   (b_i),
        .res_o (lres)
    );

    assign result_o = is_arith ? sum : lres;

    flag_alu_zdet #(.W(W)) zdet_i (
        .val_i  (result_o),
        .zero_o (zero)
    );

    always_comb begin
        st_d = st_q;
        if (valid_i && setf_i && (op != OP_RSV)) begin
            st_d.cond.carry    = is_arith ? cout : 1'b0;
            st_d.cond.overflow = is_arith ? ovf  : 1'b0;
            st_d.cond.zero     = zero;
            st_d.cond.negative = result_o[W-1];
            st_d.cond.parity   = ~^result_o;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.cond;
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         valid_i,
    input logic         setf_i,
    input logic [2:0]   op_i,
    input logic [W-1:0] result_o,
    input logic [4:0]   flags_o
);
    logic wr;
    assign wr = valid_i && setf_i && (op_i != 3'd7);

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |=> flags_o == 5'd0); // R1
    AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> flags_o[1] == ($past(result_o) == '0)); // R6
    AST_NEG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> flags_o[2] == $past(result_o[W-1])); // R7
    AST_PARITY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> flags_o[4] == ~^$past(result_o)); // R8
    AST_LOGIC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && op_i[2]) |=> (flags_o[0] == 1'b0) && (flags_o[3] == 1'b0)); // R9
    AST_HOLD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(flags_o)); // R10
    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'd7) |-> result_o == '0); // R11
endmodule

bind flag_alu flag_alu_chk #(.W(W)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .valid_i  (valid_i),
    .setf_i   (setf_i),
    .op_i     (op_i),
    .result_o (result_o),
    .flags_o  (flags_o)
);

// File: tb/flag_alu_tb_top.sv
`timescale 1ns/1ps
module flag_alu_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_i = 1'b0, setf_i = 1'b0;
    logic [2:0]  op_i = 3'd0;
    logic [31:0] a_i = '0, b_i = '0;
    logic [31:0] result_o;
    logic [4:0]  flags_o;

    int n_chk = 0, n_fail = 0;
    logic [4:0] mflags = '0;

    always #2.5 clk = ~clk;

    flag_alu dut_i (.clk(clk), .rst_n(rst_n), .valid_i(valid_i), .setf_i(setf_i),
                    .op_i(op_i), .a_i(a_i), .b_i(b_i), .result_o(result_o),
                    .flags_o(flags_o));

    // {parity, overflow, negative, zero, carry, result}
    function automatic logic [36:0] model(input logic [2:0] op, input logic [31:0] a,
                                          input logic [31:0] b, input logic cq);
        logic [32:0] s; logic [31:0] bb, r; logic c, v, ci, ar;
        ar = (op < 3'd4);
        bb = op[1] ? ~b : b;
        ci = (op == 3'd0) ? 1'b0 : (op == 3'd2) ? 1'b1 : cq;
        s  = {1'b0, a} + {1'b0, bb} + {32'd0, ci};
        case (op)
            3'd4: r = a & b;
            3'd5: r = a | b;
            3'd6: r = a ^ b;
            3'd7: r = '0;
            default: r = s[31:0];
        endcase
        c = ar ? s[32] : 1'b0;
        v = ar ? ((a[31] == bb[31]) && (r[31] != a[31])) : 1'b0;
        return {~^r, v, r[31], (r == 32'd0), c, r};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_op(input logic [2:0] op, input logic [31:0] a, input logic [31:0] b,
                         input logic sf, input logic vl);
        logic [36:0] m;
        @(negedge clk);
        op_i = op; a_i = a; b_i = b; setf_i = sf; valid_i = vl;
        m = model(op, a, b, mflags[0]);
        #1;
        check((op == 3'd1 || op == 3'd3) ? "R3 result" : (op == 3'd7) ? "R11 result" : "R2 result",
              result_o, m[31:0]);
        @(posedge clk);
        if (vl && sf && op != 3'd7) mflags = m[36:32];
        #1;
        check((vl && sf && op != 3'd7) ? "R4/R5/R6/R7/R8/R9 flags" :
              (op == 3'd7) ? "R11 flags hold" : "R10 flags hold",
              {27'd0, flags_o}, {27'd0, mflags});
    endtask

    function automatic logic [31:0] pick();
        case ($urandom % 6)
            0: return 32'h0000_0000;
            1: return 32'hFFFF_FFFF;
            2: return 32'h8000_0000;
            3: return 32'h7FFF_FFFF;
            default: return $urandom;
        endcase
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [63:0] x, y, s64;
        logic [31:0] lo;
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1 check("R1 reset flags", {27'd0, flags_o}, 32'd0);
        @(negedge clk) rst_n = 1'b1;

        // R4 R6: all-ones plus one wraps to zero with carry
        do_op(3'd0, 32'hFFFF_FFFF, 32'd1, 1'b1, 1'b1);
        check("R4 carry", {31'd0, flags_o[0]}, 32'd1);
        check("R6 zero", {31'd0, flags_o[1]}, 32'd1);
        // R5: positive overflow
        do_op(3'd0, 32'h7FFF_FFFF, 32'd1, 1'b1, 1'b1);
        check("R5 overflow", {31'd0, flags_o[3]}, 32'd1);
        check("R7 negative", {31'd0, flags_o[2]}, 32'd1);
        // R4: subtract equal, no borrow -> carry 1
        do_op(3'd2, 32'd5, 32'd5, 1'b1, 1'b1);
        check("R4 sub no borrow", {31'd0, flags_o[0]}, 32'd1);
        // R4: 0 - 1 borrows -> carry 0
        do_op(3'd2, 32'd0, 32'd1, 1'b1, 1'b1);
        check("R4 sub borrow", {31'd0, flags_o[0]}, 32'd0);
        // R8: 3 ones -> odd -> parity 0
        do_op(3'd5, 32'd7, 32'd0, 1'b1, 1'b1);
        check("R8 parity odd", {31'd0, flags_o[4]}, 32'd0);
        // R9: logic clears carry/overflow after they were set
        do_op(3'd0, 32'hFFFF_FFFF, 32'h8000_0000, 1'b1, 1'b1);
        do_op(3'd6, 32'hF0F0_F0F0, 32'h0F0F_0F0F, 1'b1, 1'b1);
        check("R9 carry cleared", {30'd0, flags_o[3], flags_o[0]}, 32'd0);
        // R10: non-flag form and invalid strobe hold flags
        do_op(3'd0, 32'hFFFF_FFFF, 32'd1, 1'b0, 1'b1);
        do_op(3'd0, 32'hFFFF_FFFF, 32'd1, 1'b1, 1'b0);
        // R11: reserved opcode
        do_op(3'd7, 32'h1234_5678, 32'h1, 1'b1, 1'b1);

        // R3: chained 64-bit add and subtract
        for (int k = 0; k < 40; k++) begin
            x = {$urandom, $urandom}; y = {$urandom, $urandom};
            if (k == 0) begin x = 64'h0000_0000_FFFF_FFFF; y = 64'd1; end
            do_op(3'd0, x[31:0], y[31:0], 1'b1, 1'b1);
            lo = result_o;
            do_op(3'd1, x[63:32], y[63:32], 1'b0, 1'b1);
            s64 = x + y;
            check("R3 64-bit add", result_o, s64[63:32]);
            check("R3 64-bit add low", lo, s64[31:0]);
            do_op(3'd2, x[31:0], y[31:0], 1'b1, 1'b1);
            do_op(3'd3, x[63:32], y[63:32], 1'b0, 1'b1);
            s64 = x - y;
            check("R3 64-bit sub", result_o, s64[63:32]);
        end

        // random mix
        for (int k = 0; k < 600; k++)
            do_op(3'($urandom % 8), pick(), pick(), 1'($urandom % 4 != 0), 1'($urandom % 8 != 0));

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule